// File: doc/BRIEF.md
# Configurable SPI Transfer Engine

This block moves 8-bit frames over a single-lane serial link and acts either as the clock source (master) or as a follower of an external clock and select line (slave). A 10-bit configuration word, written through a simple write port and always readable, selects the role, the idle clock level, the bit order, a power-of-two clock divider, a listen-only option and a software override for the select line. The clock phase is fixed: each bit is sampled on the first clock edge of its period and the outgoing bit changes on the second edge.

In master mode a frame starts when the host presents a byte with `tx_valid` while the engine is idle. The engine then produces 16 half-periods of SCK and shifts the byte out on `sdo` while sampling `sdi`. In slave mode the external SCK and select input pass through a synchronizer. A frame runs while the effective select is low and loads `tx_data` at the moment selection begins. Deselection in mid-frame discards the partial byte. In both roles `busy` marks a frame in progress, and the completed byte appears on `rx_data` with a one-cycle `rx_valid` pulse.

The controller is a three-state machine. ST_IDLE waits. It moves to ST_SHIFT on a master start (enabled, master, `tx_valid`) or a slave start (enabled, slave, effective select low). ST_SHIFT runs the bits. It returns to ST_IDLE when the engine is disabled or, in slave mode, when select rises. It moves to ST_DONE on the second edge of the last bit. ST_DONE lasts one cycle and always returns to ST_IDLE.

Top module: `spi_xfer_engine`

## Requirements
- R1: Configuration bits [6:4] hold a divider code k. In master mode each SCK half-period lasts 2^k clock cycles, so one bit takes 2^(k+1) cycles.
- R2: Configuration bit 2 sets the SCK rest level: 0 rests low, 1 rests high. Outside a master frame `sck_o` equals this level.
- R3: Configuration bit 3 sets the shift order, for both sent and received bits: 0 sends and receives the most significant bit first, 1 the least significant bit first.
- R4: Configuration bit 1 selects master (1) or slave (0). A master drives SCK with `sck_oe` high. A slave keeps `sck_oe` low and takes its clock from `sck_i`.
- R5: Configuration bit 0 enables the engine. After reset the configuration reads 0, and while bit 0 is 0 no frame starts, `busy` stays low and `sdo_oe` and `sck_oe` are low.
- R6: Configuration bit 8 set makes the effective select equal to bit 9 and ignores `nss_i`. When bit 8 is clear, `nss_i` is the effective select (active low) and bit 9 has no effect.
- R7: Configuration bit 7 set holds `sdo_oe` low while frames still run and receive data. When it is clear, `sdo_oe` is high in master mode and in a selected slave.
- R8: A write leaves configuration bits [6:1] unchanged when it arrives while `busy` is high. Bits 0, 7, 8 and 9 always take the written value. `cfg_rdata` returns the stored word.
- R9: `sdi` is sampled on the first SCK edge of each bit, the edge that leaves the rest level. `sdo` changes on the second edge.
- R10: In master mode a frame starts on the clock edge where `tx_valid` is high, the engine is idle and enabled. This happens whether or not bit 7 is set, and `busy` rises on that edge.
- R11: In slave mode a rise of the effective select during a frame returns the engine to idle. It produces no `rx_valid`, and the next frame starts from bit 0 with freshly loaded `tx_data`.
- R12: After the last bit, `rx_valid` is high for exactly one cycle and `rx_data` holds the received byte. `busy` falls on that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word to write |
| cfg_rdata | output | 10 | Stored configuration word |
| tx_valid | input | 1 | Master: start a frame with tx_data |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | One-cycle pulse when a byte has been received |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Frame in progress |
| sck_i | input | 1 | External serial clock (slave) |
| sck_o | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Enable for the serial clock driver |
| nss_i | input | 1 | Select pin, active low (slave) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for the serial data driver |

## Verification
The assertions assume that the host raises `tx_valid` only while `busy` is low. They also assume that the external SCK in slave mode has half-periods several clock cycles long, so that the synchronizer sees every edge, and that `sdi` stays steady around each sampling edge. The stimulus holds slave SCK levels for six cycles and changes slave data only while SCK rests. In master mode, `sdi` changes only at whole bit boundaries computed from the divider.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int SPI_FRAME_W = 8;
    localparam int SPI_BAUD_W  = 3;
    localparam int SPI_CFG_W   = SPI_BAUD_W + 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic                  ssi;
        logic                  ssm;
        logic                  rx_only;
        logic [SPI_BAUD_W-1:0] baud;
        logic                  lsb_first;
        logic                  cpol;
        logic                  master;
        logic                  en;
    } spi_cfg_t;
endpackage

// File: rtl/spi_cfg_reg.sv
module spi_cfg_reg
    import spi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SPI_CFG_W-1:0] wdata,
    input  logic                 busy,
    output spi_cfg_t             cfg
);
    spi_cfg_t w;
    assign w = spi_cfg_t'(wdata);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.en      <= w.en;
            cfg.rx_only <= w.rx_only;
            cfg.ssm     <= w.ssm;
            cfg.ssi     <= w.ssi;
            if (!busy) begin
                cfg.master    <= w.master;
                cfg.cpol      <= w.cpol;
                cfg.lsb_first <= w.lsb_first;
                cfg.baud      <= w.baud;
            end
        end
    end

    // R8: frame-shaping fields hold while a frame runs
    p_locked_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cfg.baud) && $stable(cfg.cpol) &&
                  $stable(cfg.lsb_first) && $stable(cfg.master)));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int BAUD_W = spi_pkg::SPI_BAUD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [BAUD_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = 1 << BAUD_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(1) << code) - CNT_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R1: above the smallest divider a half-period is never a single cycle
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && code != '0) |=> !tick);
endmodule

// File: rtl/spi_slave_sync.sv
module spi_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic nss_i,
    output logic sck_s,
    output logic sck_d,
    output logic nss_s
);
    logic [STAGES:0]   sck_chain;
    logic [STAGES-1:0] nss_chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_chain <= '0;
            nss_chain <= '1;
        end else begin
            sck_chain <= {sck_chain[STAGES-1:0], sck_i};
            nss_chain <= {nss_chain[STAGES-2:0], nss_i};
        end
    end

    assign sck_s = sck_chain[STAGES-1];
    assign sck_d = sck_chain[STAGES];
    assign nss_s = nss_chain[STAGES-1];
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_pkg::*;
#(
    parameter int FRAME_W     = SPI_FRAME_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SPI_CFG_W-1:0] cfg_wdata,
    output logic [SPI_CFG_W-1:0] cfg_rdata,
    input  logic                 tx_valid,
    input  logic [FRAME_W-1:0]   tx_data,
    output logic                 rx_valid,
    output logic [FRAME_W-1:0]   rx_data,
    output logic                 busy,
    input  logic                 sck_i,
    output logic                 sck_o,
    output logic                 sck_oe,
    input  logic                 nss_i,
    input  logic                 sdi,
    output logic                 sdo,
    output logic                 sdo_oe
);
    localparam int              BIT_W    = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    spi_cfg_t          cfg;
    xfer_state_e       state_q, state_d;
    logic              tick, sck_s, sck_d, nss_s, ss_eff;
    logic              phase_q, sck_r, lead, trail, sck_moved;
    logic [BIT_W-1:0]  bit_q;
    logic [FRAME_W-1:0] tx_sh, rx_sh, rx_hold;

    spi_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .busy  (busy),
        .cfg   (cfg)
    );

    spi_baud_gen #(.BAUD_W(SPI_BAUD_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state_q == ST_SHIFT) && cfg.master),
        .code  (cfg.baud),
        .tick  (tick)
    );

    spi_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_i (sck_i),
        .nss_i (nss_i),
        .sck_s (sck_s),
        .sck_d (sck_d),
        .nss_s (nss_s)
    );

    assign ss_eff    = cfg.ssm ? cfg.ssi : nss_s;
    assign sck_moved = (sck_s != sck_d);

    // edge qualification: first edge leaves rest level, second returns to it
    always_comb begin
        if (state_q != ST_SHIFT) begin
            lead  = 1'b0;
            trail = 1'b0;
        end else if (cfg.master) begin
            lead  = tick && !phase_q;
            trail = tick && phase_q;
        end else begin
            lead  = sck_moved && (sck_s != cfg.cpol) && !phase_q;
            trail = sck_moved && (sck_s == cfg.cpol) && phase_q;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg.en && (cfg.master ? tx_valid : !ss_eff)) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!cfg.en) begin
                    state_d = ST_IDLE;
                end else if (!cfg.master && ss_eff) begin
                    state_d = ST_IDLE;
                end else if (trail && bit_q == LAST_BIT) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_hold <= '0;
            bit_q   <= '0;
            phase_q <= 1'b0;
            sck_r   <= 1'b0;
        end else if (state_q == ST_IDLE && state_d == ST_SHIFT) begin
            tx_sh   <= tx_data;
            bit_q   <= '0;
            phase_q <= 1'b0;
            sck_r   <= cfg.cpol;
        end else if (lead) begin
            phase_q <= 1'b1;
            sck_r   <= ~cfg.cpol;
            rx_sh   <= cfg.lsb_first ? {sdi, rx_sh[FRAME_W-1:1]}
                                     : {rx_sh[FRAME_W-2:0], sdi};
        end else if (trail) begin
            phase_q <= 1'b0;
            sck_r   <= cfg.cpol;
            if (bit_q == LAST_BIT) begin
                rx_hold <= rx_sh;
            end else begin
                bit_q <= bit_q + BIT_W'(1);
                tx_sh <= cfg.lsb_first ? (tx_sh >> 1) : (tx_sh << 1);
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_SHIFT);
        rx_valid  = (state_q == ST_DONE);
        rx_data   = rx_hold;
        cfg_rdata = cfg;
        sck_oe    = cfg.en && cfg.master;
        sck_o     = (cfg.master && state_q == ST_SHIFT) ? sck_r : cfg.cpol;
        sdo       = cfg.lsb_first ? tx_sh[0] : tx_sh[FRAME_W-1];
        sdo_oe    = cfg.en && !cfg.rx_only && (cfg.master || !ss_eff);
    end

    // R12: completion pulse lasts one cycle
    p_valid_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R12: busy falls on the completion cycle
    p_valid_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(busy) && !busy));

    // R5: a disabled engine is idle one cycle later
    p_off_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !busy);

    // R7: listen-only never drives the data line
    p_rxonly_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.rx_only |-> !sdo_oe);

    // R11: slave deselection abandons the frame without a completion pulse
    p_deselect_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.master && ss_eff && busy) |=> (!busy && !rx_valid));
endmodule

// File: tb/spi_xfer_engine_test.sv
module spi_xfer_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] cfg_rdata;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       busy;
    logic       s_sck = 1'b0;
    logic       sck_o, sck_oe;
    logic       s_nss = 1'b1;
    logic       sdi, m_sdi = 1'b0, s_sdi = 1'b0;
    logic       sdo, sdo_oe;

    int vecs = 0;
    int errs = 0;

    // reference model state
    logic [9:0] cm;
    logic       m_act;
    int         mt;
    int         hh;
    logic       m_busy;
    logic [7:0] m_tx = '0, m_rx = '0;
    int         rx_seen = 0;
    logic [7:0] rx_last = '0;

    always #5 clk = ~clk;

    assign sdi = cm[1] ? m_sdi : s_sdi;

    spi_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
        .sck_i(s_sck), .sck_o(sck_o), .sck_oe(sck_oe), .nss_i(s_nss),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always_comb begin
        hh     = 1 << cm[6:4];
        m_busy = m_act && (mt < 16 * hh);
    end

    // behavioural model: time since frame start in clock cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            cm    <= '0;
            m_act <= 1'b0;
            mt    <= 0;
        end else begin
            if (cfg_we) begin
                cm[0]   <= cfg_wdata[0];
                cm[9:7] <= cfg_wdata[9:7];
                if (!m_busy) cm[6:1] <= cfg_wdata[6:1];
            end
            if (m_act) begin
                if (mt >= 16 * hh) m_act <= 1'b0;
                else mt <= mt + 1;
            end else if (tx_valid && cm[0] && cm[1]) begin
                m_act <= 1'b1;
                mt    <= 0;
            end
        end
    end

    // per-clock comparison in master mode, plus slave data for the next bit
    always @(negedge clk) begin
        if (rst_n && cm[1]) begin
            logic e_sck, e_val, e_bit;
            int   b;
            e_val = m_act && (mt == 16 * hh);
            e_sck = m_busy ? (cm[2] ^ ((mt / hh) % 2 == 1)) : cm[2];
            chk(busy == m_busy, "R10 busy", busy, m_busy);
            chk(rx_valid == e_val, "R12 rx_valid", rx_valid, e_val);
            chk(sck_o == e_sck, "R1/R2 sck_o", sck_o, e_sck);
            chk(sdo_oe == (cm[0] && !cm[7]), "R7 sdo_oe", sdo_oe, cm[0] && !cm[7]);
            chk(sck_oe == cm[0], "R4 sck_oe", sck_oe, cm[0]);
            if (m_busy) begin
                b = mt / (2 * hh);
                e_bit = cm[3] ? m_tx[b] : m_tx[7 - b];
                if (!cm[7]) chk(sdo == e_bit, "R9/R3 sdo", sdo, e_bit);
                m_sdi <= cm[3] ? m_rx[b] : m_rx[7 - b];
            end
            if (e_val) chk(rx_data == m_rx, "R3/R12 rx_data", rx_data, m_rx);
        end
    end

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_seen++;
            rx_last = rx_data;
        end
    end

    task automatic wr_cfg(input logic [9:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic mstart(input logic [7:0] t, input logic [7:0] r);
        m_tx = t;
        m_rx = r;
        @(negedge clk);
        tx_data  = t;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic mwait();
        while (m_act) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic sframe(input logic [7:0] mo, input logic [7:0] so, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            s_sdi = mo[7 - b];
            repeat (6) @(negedge clk);
            chk(sdo == so[7 - b], "R9/R4 slave sdo", sdo, so[7 - b]);
            s_sck = 1'b1;
            repeat (6) @(negedge clk);
            s_sck = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int seen0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        chk(busy == 1'b0, "R5 reset busy", busy, 0);
        chk(rx_valid == 1'b0, "R5 reset rx_valid", rx_valid, 0);
        chk(cfg_rdata == 10'h0, "R5 reset cfg", cfg_rdata, 0);
        chk(sdo_oe == 1'b0 && sck_oe == 1'b0, "R5 reset oe", {sdo_oe, sck_oe}, 0);

        // master, divider 0, msb first, rest low
        wr_cfg(10'h003);
        chk(sck_oe == 1'b1 && sck_o == 1'b0, "R4/R2 master idle", {sck_oe, sck_o}, 2'b10);
        mstart(8'hA5, 8'h3C); mwait();
        // R3: lsb first, divider 2
        wr_cfg(10'h02B);
        mstart(8'h96, 8'hE1); mwait();
        // R2: rest high, divider 1
        wr_cfg(10'h017);
        chk(sck_o == 1'b1, "R2 idle high", sck_o, 1);
        mstart(8'h5A, 8'h81); mwait();
        // R8: locked fields ignored mid-frame
        mstart(8'hC7, 8'h18);
        repeat (3) @(negedge clk);
        wr_cfg(10'h03B);
        mwait();
        chk(cfg_rdata == 10'h017, "R8 cfg locked", cfg_rdata, 10'h017);
        // R7: listen-only still runs frames
        wr_cfg(10'h0B3);
        mstart(8'hFF, 8'h42); mwait();
        chk(rx_last == 8'h42, "R7 rx in listen-only", rx_last, 8'h42);
        // R1: largest divider
        wr_cfg(10'h073);
        mstart(8'h0F, 8'hF0); mwait();
        // R5: disabled engine ignores start
        wr_cfg(10'h002);
        mstart(8'h33, 8'h33);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R5 disabled busy", busy, 0);
        chk(sck_oe == 1'b0, "R5 disabled sck_oe", sck_oe, 0);

        // slave, software select deasserted
        wr_cfg(10'h301);
        chk(sck_oe == 1'b0, "R4 slave sck_oe", sck_oe, 0);
        tx_data = 8'h6B;
        wr_cfg(10'h101);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R6 ssi select", busy, 1);
        chk(sdo_oe == 1'b1, "R7 slave sdo_oe", sdo_oe, 1);
        seen0 = rx_seen;
        sframe(8'hD2, 8'h6B, 8);
        chk(rx_seen == seen0 + 1, "R12 slave pulse count", rx_seen, seen0 + 1);
        chk(rx_last == 8'hD2, "R4 slave rx", rx_last, 8'hD2);
        // R11: abort mid-frame then restart from bit 0
        wr_cfg(10'h301);
        tx_data = 8'hC3;
        wr_cfg(10'h101);
        seen0 = rx_seen;
        sframe(8'h11, 8'hC3, 3);
        wr_cfg(10'h301);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R11 abort busy", busy, 0);
        chk(rx_seen == seen0, "R11 no pulse", rx_seen, seen0);
        tx_data = 8'h9E;
        wr_cfg(10'h101);
        sframe(8'h77, 8'h9E, 8);
        chk(rx_last == 8'h77, "R11 fresh frame rx", rx_last, 8'h77);
        // R6: pin select when override clear
        wr_cfg(10'h301);
        tx_data = 8'h24;
        s_nss = 1'b1;
        wr_cfg(10'h201);
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R6 pin high idle", busy, 0);
        s_nss = 1'b0;
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R6 pin low selects", busy, 1);
        sframe(8'hB4, 8'h24, 8);
        chk(rx_last == 8'hB4, "R6 pin frame rx", rx_last, 8'hB4);
        // R6: override ignores the pin
        wr_cfg(10'h301);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R6 override deselects", busy, 0);
        // R7: slave listen-only
        wr_cfg(10'h181);
        repeat (3) @(negedge clk);
        chk(sdo_oe == 1'b0 && busy == 1'b1, "R7 slave listen-only", {sdo_oe, busy}, 2'b01);
        finish_run();
    end
endmodule